// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Registers

This block holds the configuration header that a PCI target presents to host software. It answers dword reads with the identification constants, the Command/Status pair, the class and revision word, a single 32-bit memory base address register and the subsystem identifiers. All other header offsets read as zero. Writes arrive one dword at a time. A write lands only in a cycle where the transaction-level configuration-write flag and the per-dword data-advance pulse are both high. Active-low byte enables then choose which byte lanes change.

The bus-side interface logic raises two event inputs when it detects a parity error or signals a system error. Each event sets a sticky Status bit, and software clears that bit by writing a one to it. The address decoder takes its enables from this block. These are the I/O and memory decode enables, the parity-response bit and the system-error-drive bit from Command, and the current BAR base. The BAR size is a parameter. The base's low address bits are tied to zero, so software learns the window size by writing all ones and reading the value back.

Top module: `cfg_space_regs`

## Requirements
- R1: Dword index 0 reads {DEVICE_ID, VENDOR_ID}. Index 2 reads CLASS_REV. Index 11 (offset 2Ch) reads {SUBSYS_ID, SUBSYS_VENDOR_ID}. Writes never change these values.
- R2: A register changes on a clock edge only when cfg_wr_active and data_adv are both high at that edge. Either signal alone leaves every register unchanged.
- R3: Byte enables are active low. A write changes byte lane k (bits 8k+7:8k) only when be_n[k] is 0.
- R4: Index 1 (offset 04h) reads {Status, Command}. In Command only bits 0, 1, 6 and 8 are writable and the other bits read 0. Command resets to 0.
- R5: io_space_en follows Command bit 0 and mem_space_en follows bit 1. parity_resp_en follows bit 6 and serr_drive_en follows bit 8.
- R6: A high parity_err_evt at a clock edge sets Status bit 15 (rd_data bit 31 at index 1). The bit stays set until software clears it.
- R7: A high sys_err_evt at a clock edge sets Status bit 14 (rd_data bit 30 at index 1). The bit stays set until software clears it.
- R8: A write to index 1 with be_n[3]=0 clears Status bit 15 when wr_data[31] is 1 and clears bit 14 when wr_data[30] is 1. Writing 0 to these bits has no effect. If an event and a clear of the same bit fall on the same edge, the bit stays set. Status resets to 0.
- R9: Index 4 (offset 10h) is a 32-bit non-prefetchable memory BAR. Bits [BAR_SIZE_LOG2-1:0] always read 0, and the upper bits are writable through the byte enables. bar_base outputs the same value. The BAR resets to 0.
- R10: Every index other than 0, 1, 2, 4 and 11 reads 0, including after a write to that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_active | input | 1 | High for the whole of a configuration write transaction |
| data_adv | input | 1 | One-cycle pulse per dword transferred |
| dw_index | input | ADDR_W | Dword index within the header |
| wr_data | input | 32 | Write data |
| be_n | input | 4 | Active-low byte enables |
| parity_err_evt | input | 1 | Parity error detected on the bus |
| sys_err_evt | input | 1 | System error signalled on the bus |
| rd_data | output | 32 | Read data for dw_index (combinational) |
| io_space_en | output | 1 | I/O decode enable |
| mem_space_en | output | 1 | Memory decode enable |
| parity_resp_en | output | 1 | Parity error response enable |
| serr_drive_en | output | 1 | System error drive enable |
| bar_base | output | 32 | Current BAR value for the address decoder |

## Verification
The bench instantiates the block with BAR_SIZE_LOG2 set to 8 and with distinct non-default identification constants. With a size of 8 the whole of byte lane 0 is tied to zero while lane 1 is writable. A single lane-selective write therefore covers both the masked lane and a live lane of the BAR, and an all-ones write reveals a 256-byte window. The distinct identifiers make sure that each ID dword comes from its own parameter and not from a default.

// File: rtl/cfg_regs_pkg.sv
`timescale 1ns/1ps
package cfg_regs_pkg;
  localparam int DW_ID     = 0;
  localparam int DW_CMDSTS = 1;
  localparam int DW_CLASS  = 2;
  localparam int DW_BAR    = 4;
  localparam int DW_SUBSYS = 11;

  localparam logic [15:0] CMD_WR_MASK = 16'h0143;

  // merge one byte lane under an active-low enable
  function automatic logic [7:0] lane_merge(input logic [7:0] old_b,
                                            input logic [7:0] new_b,
                                            input logic       en_n);
    return en_n ? old_b : new_b;
  endfunction

  // bits of the BAR that software may write
  function automatic logic [31:0] bar_keep_mask(input int size_log2);
    return 32'hFFFF_FFFF << size_log2;
  endfunction
endpackage

// File: rtl/cfg_cmd_status.sv
`timescale 1ns/1ps
module cfg_cmd_status
  import cfg_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [15:0] cmd_wdata,
  input  logic [1:0]  cmd_be_n,
  input  logic [1:0]  clr_wdata,
  input  logic        sts_be_n,
  input  logic        perr_evt,
  input  logic        serr_evt,
  output logic [15:0] cmd_q,
  output logic [15:0] sts_q
);
  logic        perr_q, serr_q;
  logic [15:0] cmd_next;
  logic        clr_perr, clr_serr;

  always_comb begin
    for (int k = 0; k < 2; k++)
      cmd_next[8*k +: 8] = lane_merge(cmd_q[8*k +: 8], cmd_wdata[8*k +: 8], cmd_be_n[k]);
    cmd_next = cmd_next & CMD_WR_MASK;
  end

  assign clr_perr = wr_hit && !sts_be_n && clr_wdata[1];
  assign clr_serr = wr_hit && !sts_be_n && clr_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      perr_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      if (wr_hit) cmd_q <= cmd_next;
      perr_q <= perr_evt | (perr_q & ~clr_perr);
      serr_q <= serr_evt | (serr_q & ~clr_serr);
    end
  end

  assign sts_q = {perr_q, serr_q, 14'd0};

  // R2
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(cmd_q));
  // R3
  lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cmd_be_n[0]) |=> $stable(cmd_q[7:0]));
  // R6
  perr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |=> sts_q[15]);
  // R7
  serr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_evt |=> sts_q[14]);
  // R8
  perr_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !sts_be_n && clr_wdata[1] && !perr_evt) |=> !sts_q[15]);
endmodule

// File: rtl/cfg_bar.sv
`timescale 1ns/1ps
module cfg_bar
  import cfg_regs_pkg::*;
#(
  parameter int BAR_SIZE_LOG2 = 12
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] wdata,
  input  logic [3:0]  be_n,
  output logic [31:0] bar_q
);
  localparam logic [31:0] KEEP = bar_keep_mask(BAR_SIZE_LOG2);
  logic [31:0] bar_next;

  always_comb begin
    for (int k = 0; k < 4; k++)
      bar_next[8*k +: 8] = lane_merge(bar_q[8*k +: 8], wdata[8*k +: 8], be_n[k]);
    bar_next = bar_next & KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bar_q <= '0;
    else if (wr_hit) bar_q <= bar_next;
  end

  // R9
  bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(bar_q));
endmodule

// File: rtl/cfg_read_mux.sv
`timescale 1ns/1ps
module cfg_read_mux
  import cfg_regs_pkg::*;
#(
  parameter int          ADDR_W           = 6,
  parameter int          BAR_SIZE_LOG2    = 12,
  parameter logic [15:0] VENDOR_ID        = 16'h0000,
  parameter logic [15:0] DEVICE_ID        = 16'h0000,
  parameter logic [31:0] CLASS_REV        = 32'h0,
  parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h0000,
  parameter logic [15:0] SUBSYS_ID        = 16'h0000
)(
  input  logic [ADDR_W-1:0] dw_index,
  input  logic [15:0]       cmd_q,
  input  logic [15:0]       sts_q,
  input  logic [31:0]       bar_q,
  output logic [31:0]       rd_data
);
  logic implemented;

  always_comb begin
    implemented = 1'b1;
    if      (dw_index == ADDR_W'(DW_ID))     rd_data = {DEVICE_ID, VENDOR_ID};
    else if (dw_index == ADDR_W'(DW_CMDSTS)) rd_data = {sts_q, cmd_q};
    else if (dw_index == ADDR_W'(DW_CLASS))  rd_data = CLASS_REV;
    else if (dw_index == ADDR_W'(DW_BAR))    rd_data = bar_q;
    else if (dw_index == ADDR_W'(DW_SUBSYS)) rd_data = {SUBSYS_ID, SUBSYS_VENDOR_ID};
    else begin
      rd_data     = '0;
      implemented = 1'b0;
    end
  end

  always_comb begin
    // R10
    unimpl_zero_chk: assert (implemented || rd_data == 32'd0);
    // R9
    bar_low_zero_chk: assert (dw_index != ADDR_W'(DW_BAR) ||
                              rd_data[BAR_SIZE_LOG2-1:0] == '0);
  end
endmodule

// File: rtl/cfg_space_regs.sv
`timescale 1ns/1ps
module cfg_space_regs
  import cfg_regs_pkg::*;
#(
  parameter int          ADDR_W           = 6,
  parameter int          BAR_SIZE_LOG2    = 12,
  parameter logic [15:0] VENDOR_ID        = 16'h1234,
  parameter logic [15:0] DEVICE_ID        = 16'h5678,
  parameter logic [31:0] CLASS_REV        = 32'h1180_0001,
  parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h1234,
  parameter logic [15:0] SUBSYS_ID        = 16'h0001
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_active,
  input  logic              data_adv,
  input  logic [ADDR_W-1:0] dw_index,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        be_n,
  input  logic              parity_err_evt,
  input  logic              sys_err_evt,
  output logic [31:0]       rd_data,
  output logic              io_space_en,
  output logic              mem_space_en,
  output logic              parity_resp_en,
  output logic              serr_drive_en,
  output logic [31:0]       bar_base
);
  logic        dword_we;
  logic        cmd_hit, bar_hit;
  logic [15:0] cmd_q, sts_q;
  logic [31:0] bar_q;

  assign dword_we = cfg_wr_active & data_adv;
  assign cmd_hit  = dword_we && (dw_index == ADDR_W'(DW_CMDSTS));
  assign bar_hit  = dword_we && (dw_index == ADDR_W'(DW_BAR));

  cfg_cmd_status u_cmdsts (
    .clk(clk), .rst_n(rst_n), .wr_hit(cmd_hit),
    .cmd_wdata(wr_data[15:0]), .cmd_be_n(be_n[1:0]),
    .clr_wdata(wr_data[31:30]), .sts_be_n(be_n[3]),
    .perr_evt(parity_err_evt), .serr_evt(sys_err_evt),
    .cmd_q(cmd_q), .sts_q(sts_q)
  );

  cfg_bar #(.BAR_SIZE_LOG2(BAR_SIZE_LOG2)) u_bar (
    .clk(clk), .rst_n(rst_n), .wr_hit(bar_hit),
    .wdata(wr_data), .be_n(be_n), .bar_q(bar_q)
  );

  cfg_read_mux #(
    .ADDR_W(ADDR_W), .BAR_SIZE_LOG2(BAR_SIZE_LOG2),
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_REV(CLASS_REV),
    .SUBSYS_VENDOR_ID(SUBSYS_VENDOR_ID), .SUBSYS_ID(SUBSYS_ID)
  ) u_rmux (
    .dw_index(dw_index), .cmd_q(cmd_q), .sts_q(sts_q), .bar_q(bar_q),
    .rd_data(rd_data)
  );

  assign io_space_en    = cmd_q[0];
  assign mem_space_en   = cmd_q[1];
  assign parity_resp_en = cmd_q[6];
  assign serr_drive_en  = cmd_q[8];
  assign bar_base       = bar_q;

  // R5
  dec_en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !be_n[0]) |=> (mem_space_en == $past(wr_data[1])));
endmodule

// File: tb/tb_cfg_space_regs.sv
`timescale 1ns/1ps
module tb_cfg_space_regs;
  localparam int ADDR_W = 6;
  localparam int BSZ    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_active = 1'b0, data_adv = 1'b0;
  logic [ADDR_W-1:0] dw_index = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  be_n = 4'hF;
  logic parity_err_evt = 1'b0, sys_err_evt = 1'b0;
  logic [31:0] rd_data, bar_base;
  logic io_space_en, mem_space_en, parity_resp_en, serr_drive_en;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_space_regs #(
    .ADDR_W(ADDR_W), .BAR_SIZE_LOG2(BSZ),
    .VENDOR_ID(16'hA1B2), .DEVICE_ID(16'hC3D4), .CLASS_REV(32'h0B40_0007),
    .SUBSYS_VENDOR_ID(16'h5E6F), .SUBSYS_ID(16'h7081)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_active(cfg_wr_active), .data_adv(data_adv),
    .dw_index(dw_index), .wr_data(wr_data), .be_n(be_n),
    .parity_err_evt(parity_err_evt), .sys_err_evt(sys_err_evt),
    .rd_data(rd_data), .io_space_en(io_space_en), .mem_space_en(mem_space_en),
    .parity_resp_en(parity_resp_en), .serr_drive_en(serr_drive_en),
    .bar_base(bar_base)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input logic [3:0] ben,
                    input logic act = 1'b1, input logic adv = 1'b1,
                    input logic pe = 1'b0, input logic se = 1'b0);
    @(negedge clk);
    dw_index = ADDR_W'(idx); wr_data = d; be_n = ben;
    cfg_wr_active = act; data_adv = adv; parity_err_evt = pe; sys_err_evt = se;
    @(negedge clk);
    cfg_wr_active = 1'b0; data_adv = 1'b0; parity_err_evt = 1'b0; sys_err_evt = 1'b0;
    be_n = 4'hF;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
    @(negedge clk);
    dw_index = ADDR_W'(idx);
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic pulse_evt(input logic pe, input logic se);
    @(negedge clk);
    parity_err_evt = pe; sys_err_evt = se;
    @(negedge clk);
    parity_err_evt = 1'b0; sys_err_evt = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R4 reset", 1, 32'h0);
    rd_chk("R9 reset", 4, 32'h0);
    check("R5 reset enables", {28'd0, io_space_en, mem_space_en, parity_resp_en, serr_drive_en}, 32'h0);
  endtask

  task automatic t_ids;
    rd_chk("R1 id", 0, 32'hC3D4_A1B2);
    rd_chk("R1 class", 2, 32'h0B40_0007);
    rd_chk("R1 subsys", 11, 32'h7081_5E6F);
    wr(0, 32'hFFFF_FFFF, 4'h0);
    rd_chk("R1 id after write", 0, 32'hC3D4_A1B2);
  endtask

  task automatic t_strobe;
    wr(1, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b0);
    rd_chk("R2 flag only", 1, 32'h0);
    wr(1, 32'hFFFF_FFFF, 4'h0, 1'b0, 1'b1);
    rd_chk("R2 advance only", 1, 32'h0);
  endtask

  task automatic t_cmd;
    wr(1, 32'h0000_FFFF, 4'h0);
    rd_chk("R4 writable command bits", 1, 32'h0000_0143);
    check("R5 all enables", {28'd0, io_space_en, mem_space_en, parity_resp_en, serr_drive_en}, 32'hF);
  endtask

  task automatic t_lanes;
    wr(1, 32'h0, 4'b1110);
    rd_chk("R3 lane0 only", 1, 32'h0000_0100);
    check("R5 lane0 cleared", {28'd0, io_space_en, mem_space_en, parity_resp_en, serr_drive_en}, 32'h1);
    wr(1, 32'h0, 4'b1101);
    rd_chk("R3 lane1 only", 1, 32'h0);
  endtask

  task automatic t_events;
    pulse_evt(1'b1, 1'b0);
    rd_chk("R6 parity sets bit15", 1, 32'h8000_0000);
    repeat (3) @(negedge clk);
    rd_chk("R6 sticky", 1, 32'h8000_0000);
    pulse_evt(1'b0, 1'b1);
    rd_chk("R7 system error sets bit14", 1, 32'hC000_0000);
  endtask

  task automatic t_w1c;
    wr(1, 32'h0, 4'h0);
    rd_chk("R8 write zero keeps", 1, 32'hC000_0000);
    wr(1, 32'h8000_0000, 4'b0111);
    rd_chk("R8 clear bit15", 1, 32'h4000_0000);
    wr(1, 32'h4000_0000, 4'hF);
    rd_chk("R3 R8 lane3 disabled", 1, 32'h4000_0000);
    wr(1, 32'h4000_0000, 4'b0111, 1'b1, 1'b1, 1'b0, 1'b1);
    rd_chk("R8 event wins over clear", 1, 32'h4000_0000);
    wr(1, 32'h4000_0000, 4'b0111);
    rd_chk("R8 clear bit14", 1, 32'h0);
  endtask

  task automatic t_bar;
    wr(4, 32'hFFFF_FFFF, 4'h0);
    rd_chk("R9 size probe", 4, 32'hFFFF_FF00);
    check("R9 bar_base", bar_base, 32'hFFFF_FF00);
    wr(4, 32'h1234_5678, 4'b1101);
    rd_chk("R9 R3 lane1 write", 4, 32'hFFFF_5600);
    wr(4, 32'h1234_5678, 4'h0, 1'b1, 1'b0);
    rd_chk("R9 R2 no advance", 4, 32'hFFFF_5600);
  endtask

  task automatic t_unimpl;
    rd_chk("R10 idx3", 3, 32'h0);
    rd_chk("R10 idx15", 15, 32'h0);
    wr(5, 32'hDEAD_BEEF, 4'h0);
    rd_chk("R10 idx5 after write", 5, 32'h0);
    rd_chk("R10 idx63", 63, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ids;
    t_strobe;
    t_cmd;
    t_lanes;
    t_events;
    t_w1c;
    t_bar;
    t_unimpl;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule